// File: doc/BRIEF.md
# Serial-Port to I2S Transmit Bridge

This block converts the transmit stream of a synchronous serial port master into I2S framing for an external audio codec that runs as a slave. The serial port runs in TI frame format. It supplies a bit clock, a frame pulse that is high for one clock and a serial data bit. The bridge produces the I2S bit clock, a word-select level that alternates between the left and right channels, and the I2S serial data.

The bridge has no frame counter of its own. Each frame pulse flips the word-select level, and the data is registered once so that it falls one clock behind that flip. An optional extra register on word-select lines the word-select edge up with the MSB instead of leading it by one clock. A second option inverts the output bit clock. Both options are sampled only when a frame pulse arrives. A synchronous enable parks every output at its reset value.

The bridge is valid only while the serial port streams words back to back, so that a frame pulse and clock edges keep coming. If the port's clock stops, the registers stop updating.

Top module: `ssp2i2s_tx`

## Requirements
- R1: While enabled, `sck_o` follows `clk_i` when the latched inversion setting is 0 and follows the complement of `clk_i` when it is 1 (high phase of `clk_i` gives `sck_o` = 1 XOR setting).
- R2: The word-select level toggles exactly once for every frame pulse sampled while enabled, and never changes on a clock edge without one.
- R3: With the latched word-select delay setting at 0, `ws_o` changes in the clock after the frame pulse is sampled, one clock before the word's MSB appears on `sd_o`.
- R4: With the latched word-select delay setting at 1, `ws_o` changes in the same clock as the word's MSB on `sd_o`.
- R5: `sd_o` equals the value `txd_i` had on the previous rising edge of `clk_i` (a delay of exactly one clock, MSB first as received).
- R6: After reset, `ws_o`, `sd_o` and `sck_o` are 0, and the first frame pulse afterwards drives word-select to 1.
- R7: From the edge at which `en_i` is sampled low, `ws_o`, `sd_o` and `sck_o` are held at 0, the word-select level and both settings are cleared, and frame pulses are ignored.
- R8: A change on `sck_inv_i` or `ws_late_i` takes effect only at the next frame pulse and never alters the word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial port bit clock. All registers launch on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Synchronous enable. While low, the outputs are held in their reset state |
| sck_inv_i | input | 1 | Request to invert the output bit clock |
| ws_late_i | input | 1 | Request for the one-clock word-select delay |
| frm_i | input | 1 | TI-format frame pulse, high for the clock before each MSB |
| txd_i | input | 1 | Serial transmit data from the port, MSB first |
| sck_o | output | 1 | I2S bit clock |
| ws_o | output | 1 | I2S word select (0 = left) |
| sd_o | output | 1 | I2S serial data |

## Verification
On every clock, the assertions check the one-clock data delay, the single toggle of the word-select level per frame pulse, the holding of the settings between frame pulses, and the quiet outputs while disabled. Only the bench's scenarios show where the word-select edge falls relative to the MSB under each delay setting and across a switch between settings. The same holds for the output clock polarity, for the first toggle after reset, and for the rule that a setting changed in the middle of a word waits for the next frame pulse.

// File: rtl/ssp2i2s_pkg.sv
`timescale 1ns/1ps
package ssp2i2s_pkg;
  typedef struct packed {
    logic sck_inv;
    logic ws_late;
  } cfg_t;

  localparam cfg_t CFG_RST = '{sck_inv: 1'b0, ws_late: 1'b0};
endpackage

// File: rtl/ssp2i2s_pipe.sv
`timescale 1ns/1ps
module ssp2i2s_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb stg_d[i] = en_i ? d_i : '0;
    end else begin : g_tail
      always_comb stg_d[i] = en_i ? stg_q[i-1] : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/ssp2i2s_cfg.sv
`timescale 1ns/1ps
module ssp2i2s_cfg
  import ssp2i2s_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frm_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (!en_i)      cfg_d = CFG_RST;
    else if (frm_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R8: settings move only on a frame pulse
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frm_i) |=> $stable(cfg_q));
endmodule

// File: rtl/ssp2i2s_ws.sv
`timescale 1ns/1ps
module ssp2i2s_ws #(
  parameter int WS_LAT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frm_i,
  input  logic late_i,
  output logic ws_o
);
  logic lvl_q, lvl_d;
  logic lvl_late;

  always_comb begin
    lvl_d = lvl_q;
    if (!en_i)      lvl_d = 1'b0;
    else if (frm_i) lvl_d = ~lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  ssp2i2s_pipe #(.W(1), .DEPTH(WS_LAT)) u_ws_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (lvl_q),
    .q_o   (lvl_late)
  );

  assign ws_o = late_i ? lvl_late : lvl_q;

  // R2: no level change without a frame pulse
  p_ws_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frm_i) |=> $stable(lvl_q));
  // R2: each frame pulse flips the level
  p_ws_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frm_i) |=> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/ssp2i2s_tx.sv
`timescale 1ns/1ps
module ssp2i2s_tx
  import ssp2i2s_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int DATA_LAT   = 1,
  parameter int WS_LAT     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_inv_i,
  input  logic ws_late_i,
  input  logic frm_i,
  input  logic txd_i,
  output logic sck_o,
  output logic ws_o,
  output logic sd_o
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_sync_n;
  logic                  run_q;
  cfg_t                  cfg_req, cfg_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[RST_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= en_i;
  end

  assign cfg_req = '{sck_inv: sck_inv_i, ws_late: ws_late_i};

  ssp2i2s_cfg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .en_i  (en_i),
    .frm_i (frm_i),
    .cfg_i (cfg_req),
    .cfg_o (cfg_cur)
  );

  ssp2i2s_ws #(.WS_LAT(WS_LAT)) u_ws (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .en_i  (en_i),
    .frm_i (frm_i),
    .late_i(cfg_cur.ws_late),
    .ws_o  (ws_o)
  );

  ssp2i2s_pipe #(.W(1), .DEPTH(DATA_LAT)) u_sd_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .en_i  (en_i),
    .d_i   (txd_i),
    .q_o   (sd_o)
  );

  assign sck_o = run_q & (clk_i ^ cfg_cur.sck_inv);

  // R7: disabled block drives quiet outputs
  p_disable_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !en_i |=> (!ws_o && !sd_o));

  if (DATA_LAT == 1) begin : g_sd_chk
    // R5: data leaves one clock after it arrives
    p_sd_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      en_i |=> (sd_o == $past(txd_i)));
  end
endmodule

// File: tb/ssp2i2s_tx_bench.sv
`timescale 1ns/1ps
module ssp2i2s_tx_bench;
  localparam int WORD_W = 16;

  logic clk = 1'b0;
  logic rst_n, en, inv_in, late_in, frm, txd;
  logic sck, ws, sd;

  always #10 clk = ~clk;

  ssp2i2s_tx u_ssp2i2s_tx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sck_inv_i(inv_in),
    .ws_late_i(late_in), .frm_i(frm), .txd_i(txd),
    .sck_o(sck), .ws_o(ws), .sd_o(sd)
  );

  typedef struct {
    logic  sd, ws, sck;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R2";

  // bench model state, from the requirements
  logic m_lvl = 1'b0, m_late = 1'b0, m_inv = 1'b0;

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bit clock cycle and push what must show after the next edge
  task automatic drive_cycle(logic f, logic d, logic e);
    exp_t it;
    logic old;
    @(negedge clk);
    frm = f; txd = d; en = e;
    if (!e) begin
      m_lvl = 0; m_late = 0; m_inv = 0;
      it.sd = 0; it.ws = 0; it.sck = 0; it.tag = "R7";
    end else begin
      old = m_lvl;
      if (f) begin
        m_lvl = ~m_lvl; m_late = late_in; m_inv = inv_in;
      end
      it.sd = d;
      it.ws = m_late ? old : m_lvl;
      it.sck = 1'b1 ^ m_inv;
      it.tag = cur_tag;
    end
    q.push_back(it);
  endtask

  // back-to-back words: lead pulse, then frame overlaps each word's LSB
  task automatic send_words(int n, logic [WORD_W-1:0] base, bit mid_flip);
    drive_cycle(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < n; k++) begin
      logic [WORD_W-1:0] w;
      w = base ^ (WORD_W'(k) * 16'h3B5D);
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (mid_flip && b == WORD_W / 2) begin
          inv_in = ~inv_in; late_in = ~late_in; // R8: must wait for next frame
        end
        drive_cycle((b == 0) && (k != n - 1), w[b], 1'b1);
      end
    end
  endtask

  // scoreboard monitor, samples in the high phase
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.tag == "R7" ? "R7 sd" : "R5 sd", sd, it.sd);
        check({it.tag, " ws"}, ws, it.ws);
        check(it.tag == "R7" ? "R7 sck" : "R1 sck", sck, it.sck);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; inv_in = 0; late_in = 0; frm = 0; txd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    @(posedge clk); #5;
    check("R6 ws reset", ws, 1'b0);
    check("R6 sd reset", sd, 1'b0);
    check("R6 sck reset", sck, 1'b0);

    // R2: enabled, no frame pulses, word-select stays put
    cur_tag = "R2";
    repeat (3) drive_cycle(1'b0, 1'b1, 1'b1);
    // R6 first toggle to 1, R3 early edge, R5 data delay
    cur_tag = "R3 R6";
    send_words(3, 16'hA5C3, 0);
    // R4 aligned edge with inverted clock (R1)
    inv_in = 1; late_in = 1; cur_tag = "R4";
    send_words(3, 16'h5E21, 0);
    // R8: settings flipped mid-word, honoured only at the next frame
    inv_in = 0; late_in = 0; cur_tag = "R8";
    send_words(3, 16'hF00D, 1);
    // R7: disable clears level and settings, frame ignored
    drive_cycle(1'b1, 1'b1, 1'b0);
    drive_cycle(1'b0, 1'b1, 1'b0);
    drive_cycle(1'b1, 1'b0, 1'b0);
    inv_in = 0; late_in = 1; cur_tag = "R7 R6";
    send_words(2, 16'h1234, 0);
    drive_cycle(1'b0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule